// File: doc/BRIEF.md
# Multi-Port Shared Word Store with Write-Conflict Resolution

This block is a small register-file memory that several processor ports can read and write in the same clock cycle. Every port may issue its own access in a given cycle: a read, a write, or nothing. When more than one port writes the same word in one cycle, a merge policy chosen at run time decides what is stored. The policy can store the value only when all writers agree, pick one writer at random, let the lowest-numbered port win, or store the wrapped sum of all the data.

Two run-time switches set the access discipline. Reads can be shared or exclusive, and writes can be shared or exclusive, which gives four combinations. Under an exclusive discipline, two ports that touch the same word with the same kind of access break the rule. Each of those ports gets an error flag and its access is dropped. Read data, error flags and agreement-mismatch flags all appear one cycle after the request. A read returns the word as it was before any write in the same cycle.

Top module: `cwmem_top`

## Requirements
- R1: After reset every word holds zero, and `rd_data`, `err` and `mismatch` are all zero.
- R2: A read returns data one cycle after the request. The data is the word's contents before any write made in the same cycle.
- R3: With `pol` = 2 (fixed order), the writer with the lowest port index stores its data when several ports write one word.
- R4: With `pol` = 3 (sum), the stored word is the sum of all data written to it that cycle, modulo 2^W.
- R5: With `pol` = 0 (agreement), a contested word is written when all its writers present the same value.
- R6: With `pol` = 0, if the writers to a word present differing values, the word keeps its old value. Each of those writers sees `mismatch` high in the next cycle. With any other `pol`, `mismatch` stays low.
- R7: With `pol` = 1 (random pick), the stored value equals the data of one of the ports that wrote that word that cycle. A free-running LFSR picks which one.
- R8: With `excl_wr` = 1, every port in a group of two or more writers to one word gets `err` in the next cycle, and the word is not changed. A writer never sees `err` and `mismatch` together.
- R9: With `excl_rd` = 1, every port in a group of two or more readers of one word gets `err`, and its `rd_data` is zero. A lone reader is served normally.
- R10: With both exclusive switches low, several ports may read one word in the same cycle and all get its contents, and no `err` is raised.
- R11: Writes from different ports to different words in one cycle all take effect.
- R12: A port with `req_vld` low changes no word, and in the next cycle it shows `rd_data`, `err` and `mismatch` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | P | Per-port request valid |
| req_wr | input | P | Per-port access kind: 1 write, 0 read |
| req_addr | input | P*AW | Per-port word address, port i in bits [i*AW +: AW] |
| req_wdata | input | P*W | Per-port write data, port i in bits [i*W +: W] |
| pol | input | 2 | Merge policy: 0 agreement, 1 random pick, 2 fixed order, 3 sum |
| excl_rd | input | 1 | 1 makes reads of a word exclusive |
| excl_wr | input | 1 | 1 makes writes of a word exclusive |
| rd_data | output | P*W | Per-port read data, one cycle after the request |
| err | output | P | Per-port discipline violation flag, one cycle after the request |
| mismatch | output | P | Per-port agreement-failure flag, one cycle after the request |

## Verification
Every output is registered once, so `rd_data`, `err` and `mismatch` for a request driven before clock edge N are valid after edge N and are sampled at the following falling edge. A stored word becomes visible to a read issued in the cycle after the write. Each table vector therefore spends one cycle on the access, checks the flags, and then spends one more cycle reading the word back through port 0. The read-before-write check places a write and a read to the same word in one cycle and expects the old value.

// File: rtl/cwmem_pkg.sv
package cwmem_pkg;
  typedef enum logic [1:0] {
    POL_AGREE = 2'd0,
    POL_RAND  = 2'd1,
    POL_FIXED = 2'd2,
    POL_SUM   = 2'd3
  } pol_e;
endpackage

// File: rtl/cwmem_rst_sync.sv
module cwmem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      srst_n  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      srst_n  <= stage_q;
    end
  end
endmodule

// File: rtl/cwmem_lfsr.sv
module cwmem_lfsr #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [LW-1:0] state
);
  logic [LW-1:0] state_nxt;
  logic          fb;

  // x^8 + x^6 + x^5 + x^4 + 1, folded onto the low bits for other widths
  always_comb begin
    fb        = state[LW-1] ^ state[(LW*6)/8-1] ^ state[(LW*5)/8-1] ^ state[(LW*4)/8-1];
    state_nxt = {state[LW-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= {{(LW-1){1'b0}}, 1'b1};
    else        state <= state_nxt;
  end
endmodule

// File: rtl/cwmem_resolve.sv
module cwmem_resolve #(
  parameter int P   = 4,
  parameter int W   = 8,
  parameter int AW  = 4,
  parameter int PW  = 2,
  parameter int IDX = 0
) (
  input  logic [P-1:0]    vld,
  input  logic [P-1:0]    wr,
  input  logic [P*AW-1:0] addr,
  input  logic [P*W-1:0]  wdata,
  input  logic [1:0]      pol,
  input  logic [PW-1:0]   start,
  output logic            w_conf,
  output logic            r_conf,
  output logic            leader,
  output logic            differ,
  output logic [W-1:0]    value
);
  import cwmem_pkg::*;

  logic [P-1:0] wsame, rsame;
  logic [W-1:0] sum_v, fix_v, rnd_v;
  logic         fix_f, rnd_f;
  logic [AW-1:0] my_addr;

  always_comb begin
    my_addr = addr[IDX*AW +: AW];
    for (int j = 0; j < P; j++) begin
      wsame[j] = vld[j] & wr[j]  & (addr[j*AW +: AW] == my_addr);
      rsame[j] = vld[j] & ~wr[j] & (addr[j*AW +: AW] == my_addr);
    end
    w_conf = wsame[IDX] && ($countones(wsame) > 1);
    r_conf = rsame[IDX] && ($countones(rsame) > 1);

    sum_v  = '0;
    differ = 1'b0;
    fix_v  = '0;
    fix_f  = 1'b0;
    for (int j = 0; j < P; j++) begin
      if (wsame[j]) begin
        sum_v = sum_v + wdata[j*W +: W];
        if (wdata[j*W +: W] != wdata[IDX*W +: W]) differ = 1'b1;
        if (!fix_f) begin
          fix_v = wdata[j*W +: W];
          fix_f = 1'b1;
        end
      end
    end
    leader = wsame[IDX] && (fix_v == wdata[IDX*W +: W]) && !(|(wsame & ((P'(1) << IDX) - P'(1))));

    rnd_v = '0;
    rnd_f = 1'b0;
    for (int k = 0; k < P; k++) begin
      if (!rnd_f && wsame[(int'(start) + k) % P]) begin
        rnd_v = wdata[((int'(start) + k) % P)*W +: W];
        rnd_f = 1'b1;
      end
    end

    unique case (pol_e'(pol))
      POL_AGREE: value = wdata[IDX*W +: W];
      POL_RAND:  value = rnd_v;
      POL_FIXED: value = fix_v;
      default:   value = sum_v;
    endcase
  end
endmodule

// File: rtl/cwmem_top.sv
module cwmem_top #(
  parameter int P     = 4,
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int LW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW   = (P > 1) ? $clog2(P) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [P-1:0]    req_vld,
  input  logic [P-1:0]    req_wr,
  input  logic [P*AW-1:0] req_addr,
  input  logic [P*W-1:0]  req_wdata,
  input  logic [1:0]      pol,
  input  logic            excl_rd,
  input  logic            excl_wr,
  output logic [P*W-1:0]  rd_data,
  output logic [P-1:0]    err,
  output logic [P-1:0]    mismatch
);
  import cwmem_pkg::*;

  logic          srst_n;
  logic [LW-1:0] lfsr_q;
  logic [P-1:0]  w_conf, r_conf, leader, differ, commit;
  logic [W-1:0]  value [P];
  logic [W-1:0]  mem_q   [DEPTH];
  logic [W-1:0]  mem_nxt [DEPTH];
  logic [DEPTH-1:0] mem_en;
  logic [P*W-1:0] rd_nxt;
  logic [P-1:0]  err_nxt, mm_nxt;

  cwmem_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  cwmem_lfsr #(.LW(LW)) u_lfsr (.clk(clk), .rst_n(srst_n), .state(lfsr_q));

  for (genvar g = 0; g < P; g++) begin : g_port
    cwmem_resolve #(.P(P), .W(W), .AW(AW), .PW(PW), .IDX(g)) u_res (
      .vld   (req_vld),
      .wr    (req_wr),
      .addr  (req_addr),
      .wdata (req_wdata),
      .pol   (pol),
      .start (lfsr_q[PW-1:0]),
      .w_conf(w_conf[g]),
      .r_conf(r_conf[g]),
      .leader(leader[g]),
      .differ(differ[g]),
      .value (value[g])
    );
  end

  always_comb begin
    for (int i = 0; i < P; i++) begin
      logic wbad, rbad, agree_fail, is_w, is_r;
      is_w       = req_vld[i] & req_wr[i];
      is_r       = req_vld[i] & ~req_wr[i];
      wbad       = excl_wr & w_conf[i];
      rbad       = excl_rd & r_conf[i];
      agree_fail = (pol_e'(pol) == POL_AGREE) & differ[i];
      commit[i]  = leader[i] & ~wbad & ~agree_fail;
      err_nxt[i] = wbad | rbad;
      mm_nxt[i]  = is_w & agree_fail & ~wbad;
      rd_nxt[i*W +: W] = (is_r && !rbad) ? mem_q[req_addr[i*AW +: AW]] : '0;
    end
    for (int a = 0; a < DEPTH; a++) begin
      mem_nxt[a] = mem_q[a];
      mem_en[a]  = 1'b0;
      for (int i = 0; i < P; i++) begin
        if (commit[i] && (int'(req_addr[i*AW +: AW]) == a)) begin
          mem_nxt[a] = value[i];
          mem_en[a]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
    end else begin
      for (int a = 0; a < DEPTH; a++) if (mem_en[a]) mem_q[a] <= mem_nxt[a];
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_data  <= '0;
      err      <= '0;
      mismatch <= '0;
    end else begin
      rd_data  <= rd_nxt;
      err      <= err_nxt;
      mismatch <= mm_nxt;
    end
  end
endmodule

// File: rtl/cwmem_chk.sv
module cwmem_chk #(
  parameter int P  = 4,
  parameter int W  = 8,
  parameter int AW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [P-1:0]    req_vld,
  input logic [P-1:0]    req_wr,
  input logic [1:0]      pol,
  input logic            excl_rd,
  input logic            excl_wr,
  input logic [P*W-1:0]  rd_data,
  input logic [P-1:0]    err,
  input logic [P-1:0]    mismatch
);
  for (genvar i = 0; i < P; i++) begin : g_chk
    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld[i] |=> (!err[i] && !mismatch[i] && rd_data[i*W +: W] == '0));
    // R10
    shared_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!excl_rd && !excl_wr) |=> !err[i]);
    // R6
    mismatch_only_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pol != 2'd0) |=> !mismatch[i]);
    // R9
    denied_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld[i] && !req_wr[i]) |=> (!err[i] || rd_data[i*W +: W] == '0));
    // R8
    err_mm_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(err[i] && mismatch[i]));
  end
endmodule

bind cwmem_top cwmem_chk #(.P(P), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(srst_n), .req_vld(req_vld), .req_wr(req_wr), .pol(pol),
  .excl_rd(excl_rd), .excl_wr(excl_wr), .rd_data(rd_data), .err(err),
  .mismatch(mismatch)
);

// File: tb/test_cwmem_top.sv
module test_cwmem_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  vld = '0, wr = '0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  pol = '0;
  logic        exr = 1'b0, exw = 1'b0;
  logic [31:0] rd_data;
  logic [3:0]  err, mismatch;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cwmem_top i_cwmem_top (
    .clk(clk), .rst_n(rst_n), .req_vld(vld), .req_wr(wr), .req_addr(addr),
    .req_wdata(wdata), .pol(pol), .excl_rd(exr), .excl_wr(exw),
    .rd_data(rd_data), .err(err), .mismatch(mismatch)
  );

  typedef struct packed {
    logic [1:0]  pol;
    logic        exw;
    logic [3:0]  vld;
    logic [3:0]  wr;
    logic [15:0] addr;
    logic [31:0] data;
    logic [3:0]  chk;
    logic [7:0]  exp;
    logic [3:0]  eerr;
    logic [3:0]  emm;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{2'd2, 1'b0, 4'hF, 4'hF, 16'h3333, 32'h44332211, 4'h3, 8'h11, 4'h0, 4'h0}, // R3
    '{2'd2, 1'b0, 4'hC, 4'hC, 16'h5500, 32'h66550000, 4'h5, 8'h55, 4'h0, 4'h0}, // R3
    '{2'd3, 1'b0, 4'hF, 4'hF, 16'h7777, 32'h05109080, 4'h7, 8'h25, 4'h0, 4'h0}, // R4 wrap
    '{2'd3, 1'b0, 4'h2, 4'h2, 16'h0080, 32'h00007F00, 4'h8, 8'h7F, 4'h0, 4'h0}, // R4
    '{2'd0, 1'b0, 4'h5, 4'h5, 16'h0909, 32'h00A500A5, 4'h9, 8'hA5, 4'h0, 4'h0}, // R5
    '{2'd0, 1'b0, 4'h3, 4'h3, 16'h0099, 32'h00000201, 4'h9, 8'hA5, 4'h0, 4'h3}, // R6
    '{2'd2, 1'b1, 4'hA, 4'hA, 16'h3030, 32'hFF00EE00, 4'h3, 8'h11, 4'hA, 4'h0}, // R8
    '{2'd2, 1'b1, 4'hF, 4'hF, 16'h4210, 32'h04030201, 4'h4, 8'h04, 4'h0, 4'h0}, // R11
    '{2'd3, 1'b0, 4'hF, 4'hF, 16'hBBAA, 32'h14100403, 4'hA, 8'h07, 4'h0, 4'h0}  // R4 R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request cycle (called at a falling edge), results sampled at the next falling edge
  task automatic access(input logic [1:0] p, input logic r_ex, input logic w_ex,
                        input logic [3:0] v, input logic [3:0] w,
                        input logic [15:0] a, input logic [31:0] d);
    pol = p; exr = r_ex; exw = w_ex; vld = v; wr = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    vld = '0; wr = '0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] val);
    access(2'd2, 1'b0, 1'b0, 4'h1, 4'h0, {12'h0, a}, 32'h0);
    val = rd_data[7:0];
  endtask

  initial begin
    logic [7:0] v8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 err", {28'h0, err}, 32'h0);
    check("R1 mismatch", {28'h0, mismatch}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      access(2'd2, 1'b0, 1'b0, 4'hF, 4'h0,
             {4'(4*k+3), 4'(4*k+2), 4'(4*k+1), 4'(4*k)}, 32'h0);
      check("R1 words zero", rd_data, 32'h0);
    end

    // table of vectors
    for (int n = 0; n < NV; n++) begin
      access(VT[n].pol, 1'b0, VT[n].exw, VT[n].vld, VT[n].wr, VT[n].addr, VT[n].data);
      check($sformatf("R6/R8 err vec%0d", n), {28'h0, err}, {28'h0, VT[n].eerr});
      check($sformatf("R6 mismatch vec%0d", n), {28'h0, mismatch}, {28'h0, VT[n].emm});
      peek(VT[n].chk, v8);
      check($sformatf("R3-R11 stored word vec%0d", n), {24'h0, v8}, {24'h0, VT[n].exp});
    end

    // R2 read-before-write: port0 writes word 3, port1 reads word 3 in the same cycle
    access(2'd2, 1'b0, 1'b0, 4'h3, 4'h1, 16'h0033, 32'h00000077);
    check("R2 old value", {24'h0, rd_data[15:8]}, 32'h11);
    peek(4'h3, v8);
    check("R2 new value next", {24'h0, v8}, 32'h77);

    // R10 shared reads of word 4
    access(2'd2, 1'b0, 1'b0, 4'hF, 4'h0, 16'h4444, 32'h0);
    check("R10 all readers", rd_data, 32'h04040404);
    check("R10 no err", {28'h0, err}, 32'h0);

    // R9 exclusive reads: ports 0,1 collide on word 4, port 2 alone on word 5
    access(2'd2, 1'b1, 1'b0, 4'h7, 4'h0, 16'h0544, 32'h0);
    check("R9 err", {28'h0, err}, 32'h3);
    check("R9 rd_data", rd_data, 32'h00550000);

    // R12 invalid write request is ignored, idle port outputs zero
    access(2'd2, 1'b0, 1'b0, 4'h0, 4'h1, 16'h0005, 32'h00000099);
    check("R12 idle outputs", {rd_data[7:0], 20'h0, err}, 32'h0);
    check("R12 idle mismatch", {28'h0, mismatch}, 32'h0);
    peek(4'h5, v8);
    check("R12 word kept", {24'h0, v8}, 32'h55);

    // R7 random pick stores one of the writers' values
    for (int it = 0; it < 8; it++) begin
      access(2'd1, 1'b0, 1'b0, 4'hF, 4'hF, 16'hCCCC, 32'h84634221);
      peek(4'hC, v8);
      checks++;
      if (!(v8 inside {8'h21, 8'h42, 8'h63, 8'h84})) begin
        errors++;
        $display("FAIL R7: actual %h expected one of 21 42 63 84", v8);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule